// File: doc/BRIEF.md
# Timed Multi-Channel Converter Scan Sequencer

This block controls one analog-to-digital converter: it decides when a scan happens and which input channel the converter looks at. A programmable prescaler slows the reference clock into a tick. Ticks pace the whole sequencer, including the warm-up counter and a wide interval timer that spaces the scans. Each time the interval expires, the sequencer steps through the channels enabled in an 8-bit mask, lowest index first. For each enabled channel it sets the mux select, raises a conversion request and waits for the converter's done strobe.

Software can switch the block into an override mode. In that mode timed scans stop and each command pulse gives exactly one conversion on a chosen channel. A second divider supplies the slow clock the converter core needs. After enable, a warm-up period of a programmed number of ticks must finish before any conversion is requested. When the interrupt source is enabled, a one-cycle interrupt pulse marks each completed scan or override sample.

Top module: `scan_seq`

## Requirements
- R1: Consecutive timed scans start exactly `max(interval,1) * max(prescale,1)` reference clock cycles apart, measured between the first conversion requests of two scans; a prescale of 0 behaves as 1.
- R2: After `enable` rises, `warm_done` stays low until `max(warm_cycles,1)` ticks have passed, which is `max(warm_cycles,1)*max(prescale,1)+1` rising edges. No request is raised while `warm_done` is low.
- R3: Within a scan, requests are issued for the channels whose mask bit is 1 in ascending index order, with `mux_sel` equal to the channel index. Channels with a 0 bit get no request.
- R4: `conv_req` and `mux_sel` hold steady until `conv_done` is seen, and `conv_req` is low in the cycle after `conv_done` is accepted. `busy` is high whenever `conv_req` is high.
- R5: A scan with an all-zero mask issues no request but still completes, so it raises the interrupt when that is enabled.
- R6: `irq` is a single-cycle pulse at each completed scan or override sample when `irq_en` is 1, and stays low when `irq_en` is 0.
- R7: With `ovr_mode` at 1, no timed scan starts, and each `ovr_cmd` pulse produces exactly one request, on channel `ovr_chan`.
- R8: An override command that arrives while a scan conversion is in flight is served right after that conversion completes. The rest of that scan is dropped.
- R9: `ovr_cmd` has no effect while `ovr_mode` is 0.
- R10: `conv_clk` toggles every `max(cdiv,1)` reference clock cycles while enabled.
- R11: Dropping `enable` clears `conv_req`, `busy` and `warm_done` by the next cycle.
- R12: A `conv_done` strobe that arrives with no request outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the block; low holds everything idle |
| prescale | input | 8 | Tick divider, 0 treated as 1 |
| interval | input | 32 | Ticks between scan starts, 0 treated as 1 |
| warm_cycles | input | 16 | Warm-up length in ticks, 0 treated as 1 |
| cdiv | input | 8 | Converter clock half period in reference cycles, 0 treated as 1 |
| chan_mask | input | 8 | Channels included in each scan, bit n selects channel n |
| ovr_mode | input | 1 | 1 selects command-driven sampling |
| ovr_cmd | input | 1 | One-cycle command pulse in override mode |
| ovr_chan | input | 3 | Channel sampled by an override command |
| irq_en | input | 1 | Enables the sequencer interrupt |
| conv_done | input | 1 | Converter completion strobe |
| conv_clk | output | 1 | Slow clock for the converter core |
| conv_req | output | 1 | Conversion request, held until done |
| mux_sel | output | 3 | Analog input select |
| busy | output | 1 | Scan or override conversion in progress |
| warm_done | output | 1 | Warm-up finished |
| irq | output | 1 | Sequencer activity interrupt pulse |

## Verification
The bench uses the default parameters: eight channels, an 8-bit prescaler, a 32-bit timer and a 16-bit warm-up count. At run time it programs an interval of 64 ticks and prescale values from 0 to 5. A modelled converter answers each request three cycles after it is raised. With these settings, three full scans of any mask fit in a few hundred cycles, so scan spacing, channel order and warm-up length can all be checked at the exact cycle. The same small interval lets mid-scan override hand-offs and empty-mask scans recur often enough to be observed several times.

// File: rtl/scan_pkg.sv
package scan_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_WARM  = 3'd1,
        ST_IDLE  = 3'd2,
        ST_SEL   = 3'd3,
        ST_CONV  = 3'd4,
        ST_OCONV = 3'd5
    } seq_state_e;

endpackage

// File: rtl/scan_tick_gen.sv
module scan_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } tick_t;

    tick_t            q, d;
    logic [DIV_W-1:0] last;

    always_comb begin
        last   = (div == '0) ? '0 : div - DIV_W'(1);
        d      = q;
        d.tick = 1'b0;
        if (!run) begin
            d.cnt = '0;
        end else if (q.cnt >= last) begin
            d.cnt  = '0;
            d.tick = 1'b1;
        end else begin
            d.cnt = q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick = q.tick;

endmodule

// File: rtl/scan_clk_div.sv
module scan_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             clk_out
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             lvl;
    } cdiv_t;

    cdiv_t            q, d;
    logic [DIV_W-1:0] last;

    always_comb begin
        last = (div == '0) ? '0 : div - DIV_W'(1);
        d    = q;
        if (!run) begin
            d = '0;
        end else if (q.cnt >= last) begin
            d.cnt = '0;
            d.lvl = ~q.lvl;
        end else begin
            d.cnt = q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign clk_out = q.lvl;

endmodule

// File: rtl/scan_chan_pick.sv
module scan_chan_pick #(
    parameter int CH_N  = 8,
    parameter int SEL_W = 3
) (
    input  logic [CH_N-1:0]  pending,
    output logic             found,
    output logic [SEL_W-1:0] idx,
    output logic [CH_N-1:0]  pending_nx
);

    logic [CH_N-1:0] hit;

    // isolate the lowest set bit: that channel is visited first
    assign hit        = pending & (~pending + CH_N'(1));
    assign found      = |pending;
    assign pending_nx = pending & ~hit;

    always_comb begin
        idx = '0;
        for (int i = 0; i < CH_N; i++) begin
            if (hit[i]) idx = SEL_W'(i);
        end
    end

endmodule

// File: rtl/scan_fsm.sv
module scan_fsm
    import scan_pkg::*;
#(
    parameter int CH_N   = 8,
    parameter int SEL_W  = 3,
    parameter int TMR_W  = 32,
    parameter int WARM_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tick,
    input  logic [TMR_W-1:0]  interval,
    input  logic [WARM_W-1:0] warm_cycles,
    input  logic [CH_N-1:0]   chan_mask,
    input  logic              ovr_mode,
    input  logic              ovr_cmd,
    input  logic [SEL_W-1:0]  ovr_chan,
    input  logic              irq_en,
    input  logic              conv_done,
    output logic              conv_req,
    output logic [SEL_W-1:0]  mux_sel,
    output logic              busy,
    output logic              warm_done,
    output logic              irq
);

    typedef struct packed {
        seq_state_e        st;
        logic [TMR_W-1:0]  timer;
        logic [WARM_W-1:0] warm;
        logic [CH_N-1:0]   rem;
        logic [SEL_W-1:0]  sel;
        logic              req;
        logic              irq;
        logic              pend;
        logic [SEL_W-1:0]  pchan;
    } fsm_t;

    fsm_t              q, d;
    logic              pick_found;
    logic [SEL_W-1:0]  pick_idx;
    logic [CH_N-1:0]   pick_rem;
    logic [TMR_W-1:0]  int_eff;
    logic [WARM_W:0]   warm_nx;
    logic              timed_run;

    scan_chan_pick #(
        .CH_N  (CH_N),
        .SEL_W (SEL_W)
    ) u_pick (
        .pending    (q.rem),
        .found      (pick_found),
        .idx        (pick_idx),
        .pending_nx (pick_rem)
    );

    assign int_eff   = (interval == '0) ? TMR_W'(1) : interval;
    assign warm_nx   = {1'b0, q.warm} + (WARM_W+1)'(1);
    assign timed_run = (q.st != ST_OFF) && (q.st != ST_WARM);

    always_comb begin
        d     = q;
        d.irq = 1'b0;

        // interval timer counts ticks since the last scan start, saturating
        if (tick && timed_run && (q.timer != '1)) begin
            d.timer = q.timer + TMR_W'(1);
        end

        unique case (q.st)
            ST_OFF: begin
                d.st    = ST_WARM;
                d.warm  = '0;
                d.timer = '0;
            end
            ST_WARM: begin
                if (tick) begin
                    if (warm_nx >= {1'b0, warm_cycles}) begin
                        d.st    = ST_IDLE;
                        d.timer = '1;
                    end else begin
                        d.warm = warm_nx[WARM_W-1:0];
                    end
                end
            end
            ST_IDLE: begin
                if (tick) begin
                    if (ovr_mode) begin
                        if (q.pend) begin
                            d.st   = ST_OCONV;
                            d.sel  = q.pchan;
                            d.req  = 1'b1;
                            d.pend = 1'b0;
                        end
                    end else if (q.timer >= int_eff) begin
                        d.st    = ST_SEL;
                        d.rem   = chan_mask;
                        d.timer = TMR_W'(1);
                    end
                end
            end
            ST_SEL: begin
                if (ovr_mode) begin
                    d.st  = ST_IDLE;
                    d.rem = '0;
                end else if (tick) begin
                    if (!pick_found) begin
                        d.st  = ST_IDLE;
                        d.irq = irq_en;
                    end else begin
                        d.st  = ST_CONV;
                        d.sel = pick_idx;
                        d.rem = pick_rem;
                        d.req = 1'b1;
                    end
                end
            end
            ST_CONV: begin
                if (conv_done) begin
                    d.st  = ST_SEL;
                    d.req = 1'b0;
                end
            end
            ST_OCONV: begin
                if (conv_done) begin
                    d.st  = ST_IDLE;
                    d.req = 1'b0;
                    d.irq = irq_en;
                end
            end
            default: d.st = ST_OFF;
        endcase

        // override commands are only honoured in override mode
        if (!ovr_mode) begin
            d.pend = 1'b0;
        end else if (ovr_cmd && !d.pend) begin
            d.pend  = 1'b1;
            d.pchan = ovr_chan;
        end

        if (!enable) begin
            d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign conv_req  = q.req;
    assign mux_sel   = q.sel;
    assign irq       = q.irq;
    assign busy      = (q.st == ST_SEL) || (q.st == ST_CONV) || (q.st == ST_OCONV);
    assign warm_done = timed_run;

endmodule

// File: rtl/scan_seq.sv
module scan_seq #(
    parameter int CH_N   = 8,
    parameter int PRE_W  = 8,
    parameter int TMR_W  = 32,
    parameter int CDIV_W = 8,
    parameter int WARM_W = 16,
    localparam int SEL_W = (CH_N > 1) ? $clog2(CH_N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [PRE_W-1:0]  prescale,
    input  logic [TMR_W-1:0]  interval,
    input  logic [WARM_W-1:0] warm_cycles,
    input  logic [CDIV_W-1:0] cdiv,
    input  logic [CH_N-1:0]   chan_mask,
    input  logic              ovr_mode,
    input  logic              ovr_cmd,
    input  logic [SEL_W-1:0]  ovr_chan,
    input  logic              irq_en,
    input  logic              conv_done,
    output logic              conv_clk,
    output logic              conv_req,
    output logic [SEL_W-1:0]  mux_sel,
    output logic              busy,
    output logic              warm_done,
    output logic              irq
);

    logic tick;

    scan_tick_gen #(
        .DIV_W (PRE_W)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (enable),
        .div   (prescale),
        .tick  (tick)
    );

    scan_clk_div #(
        .DIV_W (CDIV_W)
    ) u_cdiv (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (enable),
        .div     (cdiv),
        .clk_out (conv_clk)
    );

    scan_fsm #(
        .CH_N   (CH_N),
        .SEL_W  (SEL_W),
        .TMR_W  (TMR_W),
        .WARM_W (WARM_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .tick        (tick),
        .interval    (interval),
        .warm_cycles (warm_cycles),
        .chan_mask   (chan_mask),
        .ovr_mode    (ovr_mode),
        .ovr_cmd     (ovr_cmd),
        .ovr_chan    (ovr_chan),
        .irq_en      (irq_en),
        .conv_done   (conv_done),
        .conv_req    (conv_req),
        .mux_sel     (mux_sel),
        .busy        (busy),
        .warm_done   (warm_done),
        .irq         (irq)
    );

endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk #(
    parameter int SEL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             irq_en,
    input logic             conv_done,
    input logic             conv_req,
    input logic [SEL_W-1:0] mux_sel,
    input logic             busy,
    input logic             warm_done,
    input logic             irq
);

    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && conv_req && !conv_done) |=> conv_req);

    p_sel_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && conv_req && !conv_done) |=> $stable(mux_sel));

    p_req_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && conv_done) |=> !conv_req);

    p_busy_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> busy);

    p_warm_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !warm_done |-> !conv_req);

    p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_irq_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> !irq);

    p_disable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!conv_req && !busy && !warm_done));

endmodule

bind scan_seq scan_seq_chk #(
    .SEL_W (SEL_W)
) u_scan_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .irq_en    (irq_en),
    .conv_done (conv_done),
    .conv_req  (conv_req),
    .mux_sel   (mux_sel),
    .busy      (busy),
    .warm_done (warm_done),
    .irq       (irq)
);

// File: tb/test_scan_seq.sv
module test_scan_seq;

    localparam int LAT  = 3;
    localparam int IVAL = 64;

    typedef struct packed {
        logic [7:0] pre;
        logic [7:0] mask;
        logic [3:0] n;
        logic [2:0] first;
        logic [2:0] last;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{8'd1, 8'hFF, 4'd8, 3'd0, 3'd7},
        '{8'd0, 8'hA5, 4'd4, 3'd0, 3'd7},
        '{8'd2, 8'h18, 4'd2, 3'd3, 3'd4},
        '{8'd3, 8'h80, 4'd1, 3'd7, 3'd7},
        '{8'd5, 8'h42, 4'd2, 3'd1, 3'd6}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [7:0]  prescale = 8'd1;
    logic [31:0] interval = 32'(IVAL);
    logic [15:0] warm_cycles = 16'd2;
    logic [7:0]  cdiv = 8'd4;
    logic [7:0]  chan_mask = 8'hFF;
    logic        ovr_mode = 1'b0;
    logic        ovr_cmd = 1'b0;
    logic [2:0]  ovr_chan = 3'd0;
    logic        irq_en = 1'b1;
    logic        resp_done = 1'b0;
    logic        man_done = 1'b0;
    logic        conv_done;
    logic        conv_clk, conv_req, busy, warm_done, irq;
    logic [2:0]  mux_sel;

    assign conv_done = resp_done | man_done;

    scan_seq i_scan_seq (
        .clk(clk), .rst_n(rst_n), .enable(enable), .prescale(prescale),
        .interval(interval), .warm_cycles(warm_cycles), .cdiv(cdiv),
        .chan_mask(chan_mask), .ovr_mode(ovr_mode), .ovr_cmd(ovr_cmd),
        .ovr_chan(ovr_chan), .irq_en(irq_en), .conv_done(conv_done),
        .conv_clk(conv_clk), .conv_req(conv_req), .mux_sel(mux_sel),
        .busy(busy), .warm_done(warm_done), .irq(irq)
    );

    always #10 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    int req_cnt = 0, irq_cnt = 0, r4_viol = 0;
    int chan_log [256];
    int time_log [256];
    int rcnt = 0;
    bit finished = 1'b0;
    logic p_req = 1'b0, p_done = 1'b0, p_en = 1'b0;
    logic [2:0] p_sel = 3'd0;

    always @(posedge clk) cyc <= cyc + 1;

    // converter model: answers LAT cycles after a request appears
    always @(posedge clk) begin
        if (resp_done) begin
            resp_done <= 1'b0;
            rcnt      <= 0;
        end else if (conv_req) begin
            if (rcnt == LAT - 1) begin
                resp_done <= 1'b1;
                rcnt      <= 0;
            end else begin
                rcnt <= rcnt + 1;
            end
        end else begin
            rcnt <= 0;
        end
    end

    always @(negedge clk) begin
        if (conv_req && !p_req) begin
            chan_log[req_cnt % 256] = int'(mux_sel);
            time_log[req_cnt % 256] = cyc;
            req_cnt = req_cnt + 1;
        end
        if (irq) irq_cnt = irq_cnt + 1;
        if (p_en && enable && p_req && !p_done && (!conv_req || mux_sel != p_sel))
            r4_viol = r4_viol + 1;
        if (p_req && p_done && conv_req) r4_viol = r4_viol + 1;
        p_req  = conv_req;
        p_done = conv_done;
        p_sel  = mux_sel;
        p_en   = enable;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int nth_set(input logic [7:0] m, input int k);
        int c = 0;
        for (int b = 0; b < 8; b++) begin
            if (m[b]) begin
                if (c == k) return b;
                c++;
            end
        end
        return -1;
    endfunction

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic stop_block();
        enable = 1'b0;
        ovr_mode = 1'b0;
        cycles(4);
    endtask

    task automatic wait_reqs(input int target);
        while (req_cnt < target) @(negedge clk);
        cycles(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int base, ib, tgt, bad, ok_order;
        cycles(3);
        // reset state
        chk(!conv_req && !busy && !irq && !warm_done && mux_sel == 3'd0, "reset",
            int'({conv_req, busy, irq, warm_done}), 0);
        rst_n = 1'b1;
        cycles(2);

        // R1/R3 table of scan configurations
        foreach (VECS[v]) begin
            prescale  = VECS[v].pre;
            chan_mask = VECS[v].mask;
            base = req_cnt;
            ib   = irq_cnt;
            enable = 1'b1;
            wait_reqs(base + 3 * int'(VECS[v].n));
            ok_order = 1;
            for (int s = 0; s < 3; s++)
                for (int k = 0; k < int'(VECS[v].n); k++)
                    if (chan_log[(base + s * int'(VECS[v].n) + k) % 256] != nth_set(VECS[v].mask, k))
                        ok_order = 0;
            chk(ok_order == 1, "R3 order", ok_order, 1);
            chk(chan_log[base % 256] == int'(VECS[v].first), "R3 first",
                chan_log[base % 256], int'(VECS[v].first));
            chk(chan_log[(base + int'(VECS[v].n) - 1) % 256] == int'(VECS[v].last), "R3 last",
                chan_log[(base + int'(VECS[v].n) - 1) % 256], int'(VECS[v].last));
            tgt = IVAL * ((VECS[v].pre == 8'd0) ? 1 : int'(VECS[v].pre));
            chk(time_log[(base + 2 * int'(VECS[v].n)) % 256] - time_log[(base + int'(VECS[v].n)) % 256] == tgt,
                "R1 spacing",
                time_log[(base + 2 * int'(VECS[v].n)) % 256] - time_log[(base + int'(VECS[v].n)) % 256], tgt);
            chk(irq_cnt - ib >= 2, "R6 scan irq", irq_cnt - ib, 2);
            stop_block();
        end
        chk(r4_viol == 0, "R4 handshake", r4_viol, 0);

        // R2 exact warm-up length: prescale 2, 5 ticks -> 11 edges
        prescale = 8'd2;
        warm_cycles = 16'd5;
        base = req_cnt;
        enable = 1'b1;
        cycles(10);
        chk(!warm_done, "R2 warm early", int'(warm_done), 0);
        cycles(1);
        chk(warm_done, "R2 warm end", int'(warm_done), 1);
        chk(req_cnt == base, "R2 no req in warm", req_cnt - base, 0);
        stop_block();
        warm_cycles = 16'd2;

        // R10 converter clock divider
        for (int t = 0; t < 2; t++) begin
            int gap;
            logic lv;
            cdiv = (t == 0) ? 8'd3 : 8'd0;
            enable = 1'b1;
            cycles(8);
            lv = conv_clk;
            while (conv_clk == lv) @(negedge clk);
            lv = conv_clk;
            gap = 0;
            while (conv_clk == lv) begin
                @(negedge clk);
                gap++;
            end
            chk(gap == ((t == 0) ? 3 : 1), "R10 conv_clk", gap, (t == 0) ? 3 : 1);
            stop_block();
        end
        cdiv = 8'd4;

        // R5/R6 empty mask, then irq disabled
        prescale = 8'd1;
        chan_mask = 8'h00;
        base = req_cnt;
        ib = irq_cnt;
        enable = 1'b1;
        cycles(200);
        chk(req_cnt == base, "R5 no req", req_cnt - base, 0);
        chk(irq_cnt - ib >= 2, "R5 empty scan irq", irq_cnt - ib, 2);
        irq_en = 1'b0;
        cycles(2);
        ib = irq_cnt;
        cycles(200);
        chk(irq_cnt == ib, "R6 irq disabled", irq_cnt - ib, 0);
        irq_en = 1'b1;
        stop_block();

        // R7 override suppresses timing, one sample per command
        chan_mask = 8'hFF;
        ovr_mode = 1'b1;
        base = req_cnt;
        ib = irq_cnt;
        enable = 1'b1;
        cycles(200);
        chk(req_cnt == base, "R7 no timed scan", req_cnt - base, 0);
        ovr_chan = 3'd5;
        ovr_cmd = 1'b1;
        cycles(1);
        ovr_cmd = 1'b0;
        cycles(30);
        chk(req_cnt - base == 1, "R7 one sample", req_cnt - base, 1);
        chk(chan_log[base % 256] == 5, "R7 channel", chan_log[base % 256], 5);
        chk(irq_cnt - ib == 1, "R6 override irq", irq_cnt - ib, 1);
        // R12 stray done strobe
        man_done = 1'b1;
        cycles(1);
        man_done = 1'b0;
        cycles(10);
        chk(req_cnt - base == 1 && !busy, "R12 stray done", req_cnt - base, 1);
        ovr_chan = 3'd3;
        ovr_cmd = 1'b1;
        cycles(1);
        ovr_cmd = 1'b0;
        cycles(30);
        chk(chan_log[(base + 1) % 256] == 3 && req_cnt - base == 2, "R12 later command",
            chan_log[(base + 1) % 256], 3);
        stop_block();

        // R8 command during an in-flight scan conversion
        base = req_cnt;
        enable = 1'b1;
        while (req_cnt < base + 1) @(negedge clk);
        ovr_mode = 1'b1;
        ovr_chan = 3'd6;
        ovr_cmd = 1'b1;
        cycles(1);
        ovr_cmd = 1'b0;
        cycles(40);
        chk(req_cnt - base == 2, "R8 scan dropped", req_cnt - base, 2);
        chk(chan_log[(base + 1) % 256] == 6, "R8 served channel", chan_log[(base + 1) % 256], 6);
        stop_block();

        // R9 command ignored in timed mode
        chan_mask = 8'h80;
        base = req_cnt;
        enable = 1'b1;
        while (req_cnt < base + 1) @(negedge clk);
        cycles(10);
        ovr_chan = 3'd2;
        ovr_cmd = 1'b1;
        cycles(1);
        ovr_cmd = 1'b0;
        cycles(150);
        bad = 0;
        for (int i = base; i < req_cnt; i++)
            if (chan_log[i % 256] != 7) bad++;
        chk(bad == 0 && req_cnt - base >= 3, "R9 ignored", bad, 0);

        // R11 disable while a request is up
        base = req_cnt;
        while (req_cnt < base + 1) @(negedge clk);
        enable = 1'b0;
        cycles(1);
        chk(!conv_req && !busy && !warm_done, "R11 disable",
            int'({conv_req, busy, warm_done}), 0);
        cycles(4);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule